// File: doc/BRIEF.md
# Two-Port Semaphore Token Bank

A bank of single-bit hardware tokens that two ports share to arbitrate ownership of common resources. The bank is separate from any shared memory. Each port addresses one token with a small index. It writes a 0 to ask for that token and a 1 to give it up or to withdraw an earlier request. It then reads the token back: a 0 means the reading port holds it, and a 1 means it does not.

Every token records which port owns it and whether the other port is waiting. When the owner releases a token, a waiting port receives it in the same step, without polling again. A port that does not own a token cannot take it from the owner. A release from that port only withdraws its own waiting request. When both ports ask for the same free token in the same cycle, the left port receives it and the right port's request is kept as waiting.

Each read is captured in an output register and is held until the next read on that port. A port must not select the token bank and its memory in the same access. Such an access is discarded, and the port's error flag pulses.

Top module: `sem_token_bank`

## Requirements
- R1: After reset every token is free. Both ports read all-ones at every index, both error flags are 0, and both read registers hold all-ones.
- R2: A write of 0 to a free token makes the writing port its owner. The owner then reads 0 at that index and the other port reads 1.
- R3: The tokens are independent. An access at index i changes no other index.
- R4: A write of 0 by the non-owner leaves the owner's view unchanged and records a waiting request. A write of 1 by the non-owner withdraws that request. If the owner later releases, the token becomes free.
- R5: If the non-owner has a request waiting when the owner writes 1, the non-owner becomes the owner at that edge. The former owner reads 1 and the new owner reads 0.
- R6: A read returns one token value copied onto every bit of the read data: all-zeros or all-ones.
- R7: The read data register loads only on a valid read strobe and otherwise holds its value. A later change of ownership does not alter the held value until the next read. The held value reflects the token state from before any write made at the same edge.
- R8: Simultaneous requests by both ports for the same free token grant it to the left port and record the right port's request as waiting. A later left release hands the token to the right port.
- R9: An access strobed with both the token select and the memory select asserted changes no token and no read data. The port's error flag is 1 in the cycle after that strobe and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lt_sem_sel | input | 1 | Left port token bank select |
| lt_mem_sel | input | 1 | Left port memory select (for conflict detection only) |
| lt_wr | input | 1 | Left port write strobe |
| lt_rd | input | 1 | Left port read strobe |
| lt_idx | input | IDX_W (3) | Left port token index |
| lt_wdata | input | 1 | Left port write value: 0 requests, 1 releases |
| lt_rdata | output | DATA_W (9) | Left port read data, token value on every bit |
| lt_err | output | 1 | Left port select conflict pulse |
| rt_sem_sel | input | 1 | Right port token bank select |
| rt_mem_sel | input | 1 | Right port memory select (for conflict detection only) |
| rt_wr | input | 1 | Right port write strobe |
| rt_rd | input | 1 | Right port read strobe |
| rt_idx | input | IDX_W (3) | Right port token index |
| rt_wdata | input | 1 | Right port write value: 0 requests, 1 releases |
| rt_rdata | output | DATA_W (9) | Right port read data, token value on every bit |
| rt_err | output | 1 | Right port select conflict pulse |

## Verification
A write strobed at one rising edge updates ownership at that edge, so a read strobed in the next cycle already sees it. The read data register loads at the read strobe's edge and is valid from then until the next read. The error flag also rises at the strobe's edge and falls one cycle later. The bench drives every strobe for exactly one cycle from a falling edge and samples the outputs at the next falling edge, half a period after the register that produces them has loaded.

// File: rtl/sem_token_pkg.sv
package sem_token_pkg;
  // per-token ownership and waiting-request record
  typedef struct packed {
    logic own_l;
    logic own_r;
    logic pend_l;
    logic pend_r;
  } sem_state_t;
endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
  parameter int NUM_SEM = 8,
  localparam int IDX_W = $clog2(NUM_SEM)
) (
  input  logic               sem_sel,
  input  logic               mem_sel,
  input  logic               wr,
  input  logic               rd,
  input  logic [IDX_W-1:0]   idx,
  input  logic               wdata,
  output logic [NUM_SEM-1:0] req_vec,
  output logic [NUM_SEM-1:0] rel_vec,
  output logic               rd_ok,
  output logic               conflict
);
  logic access_ok;

  always_comb begin
    access_ok = sem_sel & ~mem_sel;
    rd_ok     = access_ok & rd;
    conflict  = sem_sel & mem_sel & (wr | rd);
  end

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_sel
    always_comb begin
      req_vec[i] = access_ok & wr & ~wdata & (idx == IDX_W'(i));
      rel_vec[i] = access_ok & wr &  wdata & (idx == IDX_W'(i));
    end
  end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_token_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_l,
  input  logic rel_l,
  input  logic req_r,
  input  logic rel_r,
  output logic own_l,
  output logic own_r
);
  sem_state_t cur_q, nxt;

  always_comb begin
    nxt = cur_q;
    unique case ({cur_q.own_l, cur_q.own_r})
      2'b00: begin
        nxt.pend_l = 1'b0;
        nxt.pend_r = 1'b0;
        if (req_l) begin
          nxt.own_l  = 1'b1;
          nxt.pend_r = req_r;
        end else if (req_r) begin
          nxt.own_r = 1'b1;
        end
      end
      2'b10: begin
        if (rel_l) begin
          nxt.own_l  = 1'b0;
          nxt.own_r  = (cur_q.pend_r & ~rel_r) | req_r;
          nxt.pend_r = 1'b0;
        end else if (req_r) begin
          nxt.pend_r = 1'b1;
        end else if (rel_r) begin
          nxt.pend_r = 1'b0;
        end
      end
      2'b01: begin
        if (rel_r) begin
          nxt.own_r  = 1'b0;
          nxt.own_l  = (cur_q.pend_l & ~rel_l) | req_l;
          nxt.pend_l = 1'b0;
        end else if (req_l) begin
          nxt.pend_l = 1'b1;
        end else if (rel_l) begin
          nxt.pend_l = 1'b0;
        end
      end
      default: nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= '0;
    else        cur_q <= nxt;
  end

  assign own_l = cur_q.own_l;
  assign own_r = cur_q.own_r;
endmodule

// File: rtl/sem_read_reg.sv
module sem_read_reg #(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 9,
  localparam int IDX_W = $clog2(NUM_SEM)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_ok,
  input  logic [IDX_W-1:0]   rd_idx,
  input  logic [NUM_SEM-1:0] own_vec,
  output logic [DATA_W-1:0]  rdata
);
  logic [DATA_W-1:0] rdata_q, rdata_nxt;

  always_comb begin
    rdata_nxt = rdata_q;
    if (rd_ok) rdata_nxt = {DATA_W{~own_vec[rd_idx]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '1;
    else        rdata_q <= rdata_nxt;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/sem_token_bank.sv
module sem_token_bank #(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 9,
  localparam int IDX_W = $clog2(NUM_SEM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lt_sem_sel,
  input  logic              lt_mem_sel,
  input  logic              lt_wr,
  input  logic              lt_rd,
  input  logic [IDX_W-1:0]  lt_idx,
  input  logic              lt_wdata,
  output logic [DATA_W-1:0] lt_rdata,
  output logic              lt_err,
  input  logic              rt_sem_sel,
  input  logic              rt_mem_sel,
  input  logic              rt_wr,
  input  logic              rt_rd,
  input  logic [IDX_W-1:0]  rt_idx,
  input  logic              rt_wdata,
  output logic [DATA_W-1:0] rt_rdata,
  output logic              rt_err
);
  // reset: asserted at once, released through two flops
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [NUM_SEM-1:0] req_l_vec, rel_l_vec, req_r_vec, rel_r_vec;
  logic [NUM_SEM-1:0] own_l_vec, own_r_vec;
  logic               rd_ok_l, rd_ok_r, conf_l, conf_r;

  sem_port_decode #(.NUM_SEM(NUM_SEM)) dec_l_i (
    .sem_sel(lt_sem_sel), .mem_sel(lt_mem_sel), .wr(lt_wr), .rd(lt_rd),
    .idx(lt_idx), .wdata(lt_wdata), .req_vec(req_l_vec), .rel_vec(rel_l_vec),
    .rd_ok(rd_ok_l), .conflict(conf_l)
  );

  sem_port_decode #(.NUM_SEM(NUM_SEM)) dec_r_i (
    .sem_sel(rt_sem_sel), .mem_sel(rt_mem_sel), .wr(rt_wr), .rd(rt_rd),
    .idx(rt_idx), .wdata(rt_wdata), .req_vec(req_r_vec), .rel_vec(rel_r_vec),
    .rd_ok(rd_ok_r), .conflict(conf_r)
  );

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_cell
    sem_cell cell_i (
      .clk(clk), .rst_n(rst_sync_n),
      .req_l(req_l_vec[i]), .rel_l(rel_l_vec[i]),
      .req_r(req_r_vec[i]), .rel_r(rel_r_vec[i]),
      .own_l(own_l_vec[i]), .own_r(own_r_vec[i])
    );
  end

  sem_read_reg #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) rreg_l_i (
    .clk(clk), .rst_n(rst_sync_n), .rd_ok(rd_ok_l), .rd_idx(lt_idx),
    .own_vec(own_l_vec), .rdata(lt_rdata)
  );

  sem_read_reg #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) rreg_r_i (
    .clk(clk), .rst_n(rst_sync_n), .rd_ok(rd_ok_r), .rd_idx(rt_idx),
    .own_vec(own_r_vec), .rdata(rt_rdata)
  );

  // select conflict pulses
  logic err_l_q, err_r_q, err_l_nxt, err_r_nxt;

  always_comb begin
    err_l_nxt = conf_l;
    err_r_nxt = conf_r;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      err_l_q <= 1'b0;
      err_r_q <= 1'b0;
    end else begin
      err_l_q <= err_l_nxt;
      err_r_q <= err_r_nxt;
    end
  end

  assign lt_err = err_l_q;
  assign rt_err = err_r_q;
endmodule

// File: rtl/sem_token_bank_chk.sv
module sem_token_bank_chk #(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 9
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              lt_sem_sel,
  input logic              lt_mem_sel,
  input logic              lt_wr,
  input logic              lt_rd,
  input logic              rt_sem_sel,
  input logic              rt_mem_sel,
  input logic              rt_wr,
  input logic              rt_rd,
  input logic [DATA_W-1:0] lt_rdata,
  input logic [DATA_W-1:0] rt_rdata,
  input logic              lt_err,
  input logic              rt_err,
  input logic [NUM_SEM-1:0] own_l_vec,
  input logic [NUM_SEM-1:0] own_r_vec
);
  // R2
  owner_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (own_l_vec & own_r_vec) == '0);

  // R6
  lt_replicated_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lt_rdata == '0) || (lt_rdata == '1));

  // R6
  rt_replicated_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rt_rdata == '0) || (rt_rdata == '1));

  // R7
  lt_rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(lt_rd && lt_sem_sel && !lt_mem_sel) |=> $stable(lt_rdata));

  // R7
  rt_rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(rt_rd && rt_sem_sel && !rt_mem_sel) |=> $stable(rt_rdata));

  // R9
  lt_err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lt_sem_sel && lt_mem_sel && (lt_wr || lt_rd)) |=> lt_err);

  // R9
  rt_err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rt_sem_sel && rt_mem_sel && (rt_wr || rt_rd)) |=> rt_err);

  // R9
  lt_conflict_ignored_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lt_sem_sel && lt_mem_sel && !rt_sem_sel) |=> ($stable(own_l_vec) && $stable(own_r_vec)));
endmodule

bind sem_token_bank sem_token_bank_chk #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_sync_n(rst_sync_n),
  .lt_sem_sel(lt_sem_sel), .lt_mem_sel(lt_mem_sel), .lt_wr(lt_wr), .lt_rd(lt_rd),
  .rt_sem_sel(rt_sem_sel), .rt_mem_sel(rt_mem_sel), .rt_wr(rt_wr), .rt_rd(rt_rd),
  .lt_rdata(lt_rdata), .rt_rdata(rt_rdata), .lt_err(lt_err), .rt_err(rt_err),
  .own_l_vec(own_l_vec), .own_r_vec(own_r_vec)
);

// File: tb/sem_token_bank_tb_top.sv
module sem_token_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_SEM = 8;
  localparam int DATA_W  = 9;
  localparam int IDX_W   = $clog2(NUM_SEM);
  localparam logic [DATA_W-1:0] ONES  = '1;
  localparam logic [DATA_W-1:0] ZEROS = '0;

  logic clk, rst_n;
  logic lt_sem_sel, lt_mem_sel, lt_wr, lt_rd, lt_wdata, lt_err;
  logic rt_sem_sel, rt_mem_sel, rt_wr, rt_rd, rt_wdata, rt_err;
  logic [IDX_W-1:0]  lt_idx, rt_idx;
  logic [DATA_W-1:0] lt_rdata, rt_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  sem_token_bank #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .lt_sem_sel(lt_sem_sel), .lt_mem_sel(lt_mem_sel), .lt_wr(lt_wr), .lt_rd(lt_rd),
    .lt_idx(lt_idx), .lt_wdata(lt_wdata), .lt_rdata(lt_rdata), .lt_err(lt_err),
    .rt_sem_sel(rt_sem_sel), .rt_mem_sel(rt_mem_sel), .rt_wr(rt_wr), .rt_rd(rt_rd),
    .rt_idx(rt_idx), .rt_wdata(rt_wdata), .rt_rdata(rt_rdata), .rt_err(rt_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [DATA_W-1:0] got, input logic [DATA_W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle_all();
    lt_sem_sel = 0; lt_mem_sel = 0; lt_wr = 0; lt_rd = 0; lt_wdata = 0; lt_idx = '0;
    rt_sem_sel = 0; rt_mem_sel = 0; rt_wr = 0; rt_rd = 0; rt_wdata = 0; rt_idx = '0;
  endtask

  task automatic sem_write(input bit p, input int i, input logic d);
    @(negedge clk);
    if (!p) begin lt_sem_sel = 1; lt_wr = 1; lt_idx = IDX_W'(i); lt_wdata = d; end
    else    begin rt_sem_sel = 1; rt_wr = 1; rt_idx = IDX_W'(i); rt_wdata = d; end
    @(negedge clk);
    idle_all();
  endtask

  task automatic both_write(input int i, input logic dl, input logic dr);
    @(negedge clk);
    lt_sem_sel = 1; lt_wr = 1; lt_idx = IDX_W'(i); lt_wdata = dl;
    rt_sem_sel = 1; rt_wr = 1; rt_idx = IDX_W'(i); rt_wdata = dr;
    @(negedge clk);
    idle_all();
  endtask

  task automatic sem_read(input bit p, input int i, output logic [DATA_W-1:0] v);
    @(negedge clk);
    if (!p) begin lt_sem_sel = 1; lt_rd = 1; lt_idx = IDX_W'(i); end
    else    begin rt_sem_sel = 1; rt_rd = 1; rt_idx = IDX_W'(i); end
    @(negedge clk);
    idle_all();
    v = p ? rt_rdata : lt_rdata;
  endtask

  task automatic expect_read(input string req, input bit p, input int i, input logic [DATA_W-1:0] exp);
    logic [DATA_W-1:0] v;
    sem_read(p, i, v);
    check(req, v, exp);
  endtask

  task automatic t_reset();
    check("R1 lt_rdata reset", lt_rdata, ONES);
    check("R1 rt_rdata reset", rt_rdata, ONES);
    check("R1 lt_err reset", DATA_W'(lt_err), ZEROS);
    check("R1 rt_err reset", DATA_W'(rt_err), ZEROS);
    for (int i = 0; i < NUM_SEM; i++) begin
      expect_read("R1 left free", 0, i, ONES);
      expect_read("R1 right free", 1, i, ONES);
    end
  endtask

  task automatic t_claim();
    sem_write(0, 3, 1'b0);
    expect_read("R2 R6 left owner reads 0", 0, 3, ZEROS);
    expect_read("R2 right sees 1", 1, 3, ONES);
    expect_read("R3 left idx 2 untouched", 0, 2, ONES);
    expect_read("R3 left idx 4 untouched", 0, 4, ONES);
    sem_write(1, 5, 1'b0);
    expect_read("R2 right owner idx5", 1, 5, ZEROS);
    expect_read("R2 left sees 1 idx5", 0, 5, ONES);
    expect_read("R3 idx3 still left", 0, 3, ZEROS);
    sem_write(1, 5, 1'b1);
    expect_read("R3 idx5 freed", 0, 5, ONES);
  endtask

  task automatic t_pending();
    sem_write(1, 3, 1'b0);
    expect_read("R4 owner view kept", 0, 3, ZEROS);
    expect_read("R4 requester not owner", 1, 3, ONES);
    sem_write(0, 3, 1'b1);
    expect_read("R5 handover right owns", 1, 3, ZEROS);
    expect_read("R5 old owner reads 1", 0, 3, ONES);
  endtask

  task automatic t_cancel();
    sem_write(0, 3, 1'b0);
    sem_write(0, 3, 1'b1);
    expect_read("R4 cancel owner kept", 1, 3, ZEROS);
    sem_write(1, 3, 1'b1);
    expect_read("R4 free after cancel left", 0, 3, ONES);
    expect_read("R4 free after cancel right", 1, 3, ONES);
  endtask

  task automatic t_simul();
    both_write(6, 1'b0, 1'b0);
    expect_read("R8 left wins", 0, 6, ZEROS);
    expect_read("R8 right loses", 1, 6, ONES);
    sem_write(0, 6, 1'b1);
    expect_read("R8 right gets after release", 1, 6, ZEROS);
    expect_read("R8 left released", 0, 6, ONES);
    sem_write(1, 6, 1'b1);
    expect_read("R8 idx6 freed", 0, 6, ONES);
  endtask

  task automatic t_hold();
    logic [DATA_W-1:0] v;
    sem_write(1, 1, 1'b0);
    sem_write(0, 1, 1'b0);
    sem_read(0, 1, v);
    check("R7 left pending reads 1", v, ONES);
    sem_write(1, 1, 1'b1);
    check("R7 held after handover", lt_rdata, ONES);
    expect_read("R7 new read shows owner", 0, 1, ZEROS);
    // read and request together on a free index: old state is captured
    @(negedge clk);
    lt_sem_sel = 1; lt_rd = 1; lt_wr = 1; lt_wdata = 0; lt_idx = IDX_W'(0);
    @(negedge clk);
    idle_all();
    check("R7 same-edge read sees prior state", lt_rdata, ONES);
    expect_read("R7 request of same edge applied", 0, 0, ZEROS);
    sem_write(0, 0, 1'b1);
    sem_write(0, 1, 1'b1);
  endtask

  task automatic t_conflict();
    @(negedge clk);
    lt_sem_sel = 1; lt_mem_sel = 1; lt_wr = 1; lt_wdata = 0; lt_idx = IDX_W'(4);
    @(negedge clk);
    idle_all();
    check("R9 left err pulse", DATA_W'(lt_err), DATA_W'(1));
    check("R9 right err quiet", DATA_W'(rt_err), ZEROS);
    @(negedge clk);
    check("R9 left err drops", DATA_W'(lt_err), ZEROS);
    expect_read("R9 conflicting write ignored", 0, 4, ONES);
    expect_read("R9 right also free", 1, 4, ONES);
    sem_write(0, 2, 1'b0);
    expect_read("R9 setup", 0, 2, ZEROS);
    @(negedge clk);
    rt_sem_sel = 1; rt_mem_sel = 1; rt_rd = 1; rt_idx = IDX_W'(3);
    lt_sem_sel = 1; lt_mem_sel = 1; lt_rd = 1; lt_idx = IDX_W'(4);
    @(negedge clk);
    idle_all();
    check("R9 right err on read", DATA_W'(rt_err), DATA_W'(1));
    check("R9 left read data unchanged", lt_rdata, ZEROS);
    sem_write(0, 2, 1'b1);
  endtask

  initial begin
    idle_all();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_claim();
    t_pending();
    t_cancel();
    t_simul();
    t_hold();
    t_conflict();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule